// File: doc/BRIEF.md
# Flux Pulse Sampler with Weak-Bit Injection

This block turns a serial stream of flux-transition bits into a one-bit read pulse, giving one result per sequencer cycle. It looks at the incoming flux bit only when a cell-boundary strobe marks the start of a flux cell. It also stores the tick time of the most recent real transition, taken from a free-running tick counter that the surrounding logic advances by four per sampling step.

When a sampled cell carries no transition and too many ticks have passed since the last real one, the block imitates an analog read amplifier reading an unformatted area. In that case it steps an 8-bit pointer through a fixed 256-bit pseudo-random pool and outputs the pool bit in place of the zero. A pool enable forces every pool bit to read as 0. A synchronous seed port lets the pointer start from a known place.

Top module: `flux_pulse_sampler`

## Requirements
- R1: After the asynchronous active-low reset, `pulse_out` is 0, the pool pointer equals `RESET_PTR`, the last-pulse time is 0 and no timeout is latched.
- R2: In a cycle where `cell_start` is 0, `pulse_out` is 0 on the following cycle.
- R3: When `cell_start` and `flux_bit` are both 1, `pulse_out` is 1 on the following cycle, and `tick_now` from that cycle becomes the last-pulse time.
- R4: When `cell_start` is 1, `flux_bit` is 0 and no timeout holds, `pulse_out` is 0 on the following cycle and the pointer keeps its value.
- R5: A timeout holds when (`tick_now` − last-pulse time) modulo 2^`TICK_W` exceeds `GAP_TICKS`. On a sampled cell with `flux_bit` 0 and a timeout, the pointer becomes pointer+1 modulo 2^`PTR_W`, and with `pool_en` at 1 `pulse_out` takes pool bit [pointer+1] on the following cycle.
- R6: With `pool_en` at 0, a substituted bit reads as 0, but the pointer still advances exactly as in R5.
- R7: Pool bit k is bit 0 of an 8-bit shift register that has started at `POOL_START` and been stepped k times. Each step shifts left and inserts s[7]^s[5]^s[4]^s[3] at bit 0.
- R8: When `seed_load` is 1, the pointer takes `seed_val` on the next cycle. This takes priority over the increment of R5, while the output of that cycle still follows R2 to R6 using the old pointer.
- R9: Once the gap has exceeded `GAP_TICKS`, the timeout stays latched until the next real transition, even if the tick counter wraps and the modulo difference becomes small again.
- R10: The pointer wraps from 2^`PTR_W`−1 to 0 during a long gap, and the pool sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one sampling step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| flux_bit | input | 1 | Current flux-stream bit, 1 means a transition |
| cell_start | input | 1 | High when the stream position is at the start of a cell |
| tick_now | input | TICK_W | Free-running tick counter value |
| pool_en | input | 1 | 1 lets pool bits through, 0 makes them read as 0 |
| seed_load | input | 1 | Loads `seed_val` into the pool pointer |
| seed_val | input | PTR_W | Pointer seed value |
| pulse_out | output | 1 | Registered read pulse |

## Verification
The bench builds the block with `TICK_W` = 10 and `RESET_PTR` = 200, and leaves `GAP_TICKS` at 96 and `PTR_W` at 8. With a 10-bit tick counter stepping by four, the counter wraps every 256 cycles, so the bench can hold a silent stretch that brings the modulo gap back under the limit and check that the latched timeout survives it. A start pointer of 200 means a long gap reaches the 255-to-0 pointer wrap after about 56 substitutions, so that wrap is checked early in the run.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // One step of the pool generator register
    function automatic logic [7:0] pool_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // Pool bit k: bit 0 after k steps from the start value
    function automatic logic pool_bit_at(input int k, input logic [7:0] start);
        logic [7:0] s;
        s = start;
        for (int i = 0; i < k; i++) s = pool_step(s);
        return s[0];
    endfunction

endpackage

// File: rtl/fps_gap_tracker.sv
module fps_gap_tracker #(
    parameter int TICK_W    = 16,
    parameter int GAP_TICKS = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              flux,
    input  logic [TICK_W-1:0] tick,
    output logic              timeout
);
    typedef struct packed {
        logic [TICK_W-1:0] last;
        logic              stale;
    } trk_t;

    trk_t st_d, st_q;
    logic [TICK_W-1:0] gap;
    logic over;
    logic real_edge;

    always_comb begin
        gap       = tick - st_q.last;
        over      = gap > TICK_W'(GAP_TICKS);
        real_edge = sample & flux;
        timeout   = sample & ~flux & (st_q.stale | over);
        st_d      = st_q;
        if (real_edge) begin
            st_d.last  = tick;
            st_d.stale = 1'b0;
        end else begin
            st_d.stale = st_q.stale | over;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fps_pool_rom.sv
module fps_pool_rom #(
    parameter int          PTR_W      = 8,
    parameter logic [7:0]  POOL_START = 8'hE1
) (
    input  logic [PTR_W-1:0] idx,
    input  logic             en,
    output logic             bit_o
);
    localparam int POOL_LEN = 1 << PTR_W;
    logic [POOL_LEN-1:0] pool;

    for (genvar k = 0; k < POOL_LEN; k++) begin : g_pool
        localparam logic B = fps_pkg::pool_bit_at(k, POOL_START);
        assign pool[k] = B;
    end

    assign bit_o = en & pool[idx];
endmodule

// File: rtl/flux_pulse_sampler.sv
module flux_pulse_sampler #(
    parameter int               TICK_W     = 16,
    parameter int               GAP_TICKS  = 96,
    parameter int               PTR_W      = 8,
    parameter logic [PTR_W-1:0] RESET_PTR  = '0,
    parameter logic [7:0]       POOL_START = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flux_bit,
    input  logic              cell_start,
    input  logic [TICK_W-1:0] tick_now,
    input  logic              pool_en,
    input  logic              seed_load,
    input  logic [PTR_W-1:0]  seed_val,
    output logic              pulse_out
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             pulse;
    } smp_t;

    smp_t st_d, st_q;
    logic timeout;
    logic [PTR_W-1:0] ptr_next;
    logic pool_bit;

    fps_gap_tracker #(.TICK_W(TICK_W), .GAP_TICKS(GAP_TICKS)) u_gap (
        .clk(clk), .rst_n(rst_n), .sample(cell_start), .flux(flux_bit),
        .tick(tick_now), .timeout(timeout)
    );

    assign ptr_next = st_q.ptr + PTR_W'(1);

    fps_pool_rom #(.PTR_W(PTR_W), .POOL_START(POOL_START)) u_rom (
        .idx(ptr_next), .en(pool_en), .bit_o(pool_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = cell_start & flux_bit;
        if (timeout) begin
            st_d.ptr   = ptr_next;
            st_d.pulse = pool_bit;
        end
        if (seed_load) st_d.ptr = seed_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= RESET_PTR;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_out = st_q.pulse;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cell_start,
    input logic             flux_bit,
    input logic             pool_en,
    input logic             seed_load,
    input logic [PTR_W-1:0] seed_val,
    input logic             timeout,
    input logic [PTR_W-1:0] ptr_q,
    input logic             pulse_out
);
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_start |=> !pulse_out);
    a_r3_edge_passes: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start && flux_bit |=> pulse_out);
    a_r4_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start && !flux_bit && !timeout && !seed_load |=> !pulse_out && $stable(ptr_q));
    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        timeout && !seed_load |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
    a_r6_pool_off: assert property (@(posedge clk) disable iff (!rst_n)
        cell_start && !flux_bit && !pool_en |=> !pulse_out);
    a_r8_seed_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> ptr_q == $past(seed_val));
endmodule

bind flux_pulse_sampler fps_checker #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .flux_bit(flux_bit),
    .pool_en(pool_en), .seed_load(seed_load), .seed_val(seed_val),
    .timeout(timeout), .ptr_q(st_q.ptr), .pulse_out(pulse_out)
);

// File: tb/sim_flux_pulse_sampler.sv
`timescale 1ns/1ps
module sim_flux_pulse_sampler;
    localparam int TW = 10;
    localparam int GAP = 96;
    localparam int RST_PTR = 200;
    localparam int START = 8'hE1;

    logic clk = 0;
    logic rst_n = 0;
    logic flux_bit = 0, cell_start = 0, pool_en = 1, seed_load = 0;
    logic [TW-1:0] tick_now = '0;
    logic [7:0] seed_val = '0;
    logic pulse_out;

    always #2 clk = ~clk;

    flux_pulse_sampler #(.TICK_W(TW), .GAP_TICKS(GAP), .PTR_W(8),
        .RESET_PTR(8'(RST_PTR)), .POOL_START(8'(START))) u0 (
        .clk(clk), .rst_n(rst_n), .flux_bit(flux_bit), .cell_start(cell_start),
        .tick_now(tick_now), .pool_en(pool_en), .seed_load(seed_load),
        .seed_val(seed_val), .pulse_out(pulse_out));

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit pool[256];
    int m_last, m_ptr, tick_i;
    bit m_stale, exp_pulse;
    string exp_tag, phase_tag;

    function automatic void build_pool();
        int s = START;
        for (int k = 0; k < 256; k++) begin
            int fb;
            pool[k] = s[0];
            fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
            s = ((s << 1) & 255) | fb;
        end
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pulse_out=%0b expected %0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Drive one cycle: at negedge check last result, apply inputs, advance model
    task automatic step(input bit cs, input bit fl, input bit en, input bit ld, input int sv);
        @(negedge clk);
        check(pulse_out, exp_pulse, exp_tag);
        cell_start = cs; flux_bit = fl; pool_en = en; seed_load = ld; seed_val = 8'(sv);
        tick_i = (tick_i + 4) % (1 << TW);
        tick_now = TW'(tick_i);
        begin
            int diff = (tick_i - m_last + (1 << TW)) % (1 << TW);
            bit over = diff > GAP;
            bit tmo = cs && !fl && (m_stale || over);
            if (!cs) begin exp_pulse = 0; exp_tag = "R2"; end
            else if (fl) begin exp_pulse = 1; exp_tag = "R3"; end
            else if (tmo) begin
                m_ptr = (m_ptr + 1) % 256;
                exp_pulse = en ? pool[m_ptr] : 0;
                exp_tag = en ? (m_ptr == 0 ? "R10" : "R5 R7") : "R6";
            end else begin exp_pulse = 0; exp_tag = "R4"; end
            if (cs && fl) begin m_last = tick_i; m_stale = 0; end
            else m_stale = m_stale || over;
            if (ld) begin m_ptr = sv % 256; exp_tag = "R8"; end
            if (phase_tag != "") exp_tag = phase_tag;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        build_pool();
        tick_i = 0; m_last = 0; m_ptr = RST_PTR; m_stale = 0;
        exp_pulse = 0; exp_tag = "R1"; phase_tag = "";
        repeat (3) @(negedge clk);
        check(pulse_out, 1'b0, "R1");
        rst_n = 1;
        // R1: pointer starts at RESET_PTR, seen by a gap right away
        for (int i = 0; i < 30; i++) step(1, 0, 1, 0, 0);
        // R2 R3 R4: dense random stream
        for (int i = 0; i < 400; i++) step($urandom % 2, ($urandom % 3) == 0, 1, 0, 0);
        // R5 R7 R10: long silent gap, pointer wraps
        step(1, 1, 1, 0, 0);
        for (int i = 0; i < 300; i++) step(1, 0, 1, 0, 0);
        // R6: pool disabled, pointer still moves
        for (int i = 0; i < 60; i++) step(1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 0);
        // R8: seed loads during timeout and during quiet cells
        step(1, 0, 1, 1, 17);
        for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 0);
        step(1, 1, 1, 1, 250);
        for (int i = 0; i < 40; i++) step(1, 0, 1, 0, 0);
        // sparse cell strobes
        for (int i = 0; i < 200; i++) step((i % 4) == 0, (i % 37) == 0, 1, 0, 0);
        // R9: tick wrap brings modulo gap back to small value
        step(1, 1, 1, 0, 0);
        for (int i = 0; i < 255; i++) step(0, 0, 1, 0, 0);
        phase_tag = "R9";
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0);
        phase_tag = "";
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) cycles++;
endmodule